// File: doc/BRIEF.md
# Period-Selectable Watchdog Timer

This block guards a processor against runaway software. Software writes one control byte that holds a 3-bit period code, an enable bit and a restart ("kick") bit. While the block is enabled it counts time in base ticks. The length of a base tick in clock cycles is a parameter, so the shortest period (nominally 16 ms) can be reached at any clock rate. The period code doubles the timeout at each step, from one base tick at code 0 to 128 base ticks at code 7. If software does not kick the block before the timeout ends, the block raises a reset request for a fixed number of cycles and then starts counting again.

Writing 1 to the kick bit makes a single one-cycle restart pulse that clears the count. The kick bit cannot be read and stays set internally until the next instruction-cycle strobe. Further kicks written while it is still set are absorbed. The read view returns the period code and the enable bit. In the kick bit's position it returns a ready flag supplied from outside the block.

Top module: `wdt_top`

## Requirements
- R1: After synchronous reset, the period code is 000, enable is 0, no restart is pending and `rst_req` is 0.
- R2: `rd_fields` shows the period code in bits 7:5 and the enable bit in bit 0. Bit 1 carries the current value of `mem_ready`, and bits 4:2 read as 0.
- R3: With enable set and no kick, `rst_req` rises exactly BASE_CYCLES × 2^code clock edges after the write edge that enabled the block (code = write data bits 7:5, enable = bit 0).
- R4: `rst_req` stays high for exactly HOLD_CYCLES cycles. It then falls, and the next request follows a full period after the fall.
- R5: A write with bit 1 set clears the count. The next request rises BASE_CYCLES × 2^code + 1 edges after that write edge.
- R6: After a kick, further writes with bit 1 set have no effect until an edge where `icyc_en` is 1 and no kick is written. After such an edge, a kick works again.
- R7: Writing enable = 0 stops the count and clears it, and drops an active `rst_req` one edge after the write. Enabling again starts a full period from zero.
- R8: When a restart pulse falls in the same cycle as expiry, the restart wins: no request is raised and a full period begins.
- R9: While the block is disabled, `rst_req` stays 0 whatever the period code and kick writes.
- R10: Write data bits 4:2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [7:5] period code, [1] kick, [0] enable |
| icyc_en | input | 1 | Instruction-cycle strobe that releases the kick bit |
| mem_ready | input | 1 | External ready flag shown in read bit 1 |
| rd_fields | output | 8 | Read view of the control fields |
| rst_req | output | 1 | Reset request, high for HOLD_CYCLES cycles on timeout |

## Verification
The expiry of the count and the restart pulse from a kick can both land on the same clock edge. The bench provokes this by timing the kick write one edge before the computed expiry edge, so that the pulse is high in the last cycle of the period. It then judges the result at the port: `rst_req` must stay low across that edge and rise only one full period later. A second collision, between disabling the block and an active request, is judged the same way, by checking that `rst_req` falls on the edge after the disable write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int SEL_W    = 3;
    localparam int TICKS_W  = (1 << SEL_W) - 1;
    localparam int DATA_W   = 8;
    localparam int SEL_LSB  = 5;
    localparam int KICK_BIT = 1;
    localparam int EN_BIT   = 0;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
    } wd_cfg_t;

    // Index of the final base tick for a period code: 2^code - 1
    function automatic logic [TICKS_W-1:0] last_tick(input logic [SEL_W-1:0] code);
        logic [TICKS_W:0] span;
        span = ({{TICKS_W{1'b0}}, 1'b1} << code) - 1'b1;
        return span[TICKS_W-1:0];
    endfunction

    function automatic wd_cfg_t decode_cfg(input logic [DATA_W-1:0] d);
        wd_cfg_t c;
        c.sel = d[SEL_LSB +: SEL_W];
        c.en  = d[EN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] read_view(input wd_cfg_t c, input logic ready);
        logic [DATA_W-1:0] v;
        v                   = '0;
        v[SEL_LSB +: SEL_W] = c.sel;
        v[KICK_BIT]         = ready;
        v[EN_BIT]           = c.en;
        return v;
    endfunction

endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              icyc_en,
    output wd_cfg_t           cfg,
    output logic              kick_pulse
);

    logic kick_flag;
    logic kick_req;

    assign kick_req = we && wdata[KICK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            kick_flag  <= 1'b0;
            kick_pulse <= 1'b0;
        end else begin
            if (we) begin
                cfg <= decode_cfg(wdata);
            end
            kick_pulse <= kick_req && !kick_flag;
            if (kick_req) begin
                kick_flag <= 1'b1;
            end else if (icyc_en) begin
                kick_flag <= 1'b0;
            end
        end
    end

    // R5
    kick_once_chk: assert property (@(posedge clk) disable iff (rst)
        kick_pulse |=> !kick_pulse);

    // R6
    kick_absorb_chk: assert property (@(posedge clk) disable iff (rst)
        (kick_req && kick_flag) |=> !kick_pulse);

    // R6
    kick_release_chk: assert property (@(posedge clk) disable iff (rst)
        (icyc_en && !kick_req) |=> !kick_flag);

endmodule

// File: rtl/wdt_base_tick.sv
module wdt_base_tick #(
    parameter int BASE_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);

    localparam int CW = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE_CYCLES - 1);

    logic [CW-1:0] cyc;

    assign tick = run && (cyc == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cyc <= '0;
        end else if (run) begin
            cyc <= tick ? '0 : cyc + 1'b1;
        end
    end

    // R3
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cyc == '0));

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cyc == '0));

endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry
    import wdt_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             tick,
    input  logic             restart,
    output logic             holding
);

    localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    logic [TICKS_W-1:0] ticks;
    logic [HW-1:0]      hold_cnt;
    logic               expire;

    assign expire = en && !holding && tick && (ticks >= last_tick(sel));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ticks    <= '0;
            hold_cnt <= '0;
            holding  <= 1'b0;
        end else if (holding) begin
            ticks <= '0;
            if (hold_cnt == HOLD_LAST) begin
                holding  <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end else if (restart) begin
            ticks <= '0;
        end else if (expire) begin
            ticks    <= '0;
            hold_cnt <= '0;
            holding  <= 1'b1;
        end else if (tick) begin
            ticks <= ticks + 1'b1;
        end
    end

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !holding);

    // R8
    kick_beats_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        (restart && !holding) |=> !holding);

    // R4
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(holding) |-> $past(tick));

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int BASE_CYCLES = 2_000_000,
    parameter int HOLD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              icyc_en,
    input  logic              mem_ready,
    output logic [DATA_W-1:0] rd_fields,
    output logic              rst_req
);

    wd_cfg_t cfg;
    logic    kick_pulse;
    logic    tick;
    logic    holding;

    wdt_ctl_reg u_ctl (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .wdata      (ctl_wdata),
        .icyc_en    (icyc_en),
        .cfg        (cfg),
        .kick_pulse (kick_pulse)
    );

    wdt_base_tick #(
        .BASE_CYCLES (BASE_CYCLES)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (cfg.en && !holding),
        .clr  (!cfg.en || kick_pulse || holding),
        .tick (tick)
    );

    wdt_expiry #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_exp (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg.en),
        .sel     (cfg.sel),
        .tick    (tick),
        .restart (kick_pulse),
        .holding (holding)
    );

    assign rst_req   = holding;
    assign rd_fields = read_view(cfg, mem_ready);

    // R9
    disabled_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && !rst_req) |=> !rst_req);

endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;

    localparam int BASE = 5;
    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       icyc_en = 1'b0;
    logic       mem_ready = 1'b0;
    logic [7:0] rd_fields;
    logic       rst_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    wdt_top #(
        .BASE_CYCLES (BASE),
        .HOLD_CYCLES (HOLD)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .icyc_en   (icyc_en),
        .mem_ready (mem_ready),
        .rd_fields (rd_fields),
        .rst_req   (rst_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; ctl_we = 1'b0; icyc_en = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = d;
        @(posedge clk);
        #1 ctl_we = 1'b0;
    endtask

    task automatic icyc;
        @(negedge clk);
        icyc_en = 1'b1;
        @(posedge clk);
        #1 icyc_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] cfgb(input int code, input bit kick, input bit en);
        return {3'(code), 3'b000, kick, en};
    endfunction

    task automatic t_reset_state;
        mem_ready = 1'b1;
        do_reset();
        chk("R1 rst_req", {7'b0, rst_req}, 8'h00);
        chk("R1 fields", rd_fields, 8'h02);
        edges(20);
        chk("R1 stays idle", {7'b0, rst_req}, 8'h00);
    endtask

    task automatic t_read_view;
        do_reset();
        mem_ready = 1'b1;
        wr(8'b101_111_1_1);
        chk("R2 R10 fields ready=1", rd_fields, 8'b101_000_1_1);
        mem_ready = 1'b0;
        #1;
        chk("R2 fields ready=0", rd_fields, 8'b101_000_0_1);
    endtask

    task automatic t_period(input int code);
        int m;
        m = BASE * (1 << code);
        do_reset();
        wr(cfgb(code, 0, 1));
        edges(m - 1);
        chk($sformatf("R3 code %0d before", code), {7'b0, rst_req}, 8'h00);
        edges(1);
        chk($sformatf("R3 code %0d at expiry", code), {7'b0, rst_req}, 8'h01);
    endtask

    task automatic t_hold;
        do_reset();
        wr(cfgb(0, 0, 1));
        edges(BASE);
        chk("R4 rise", {7'b0, rst_req}, 8'h01);
        edges(HOLD - 1);
        chk("R4 last held", {7'b0, rst_req}, 8'h01);
        edges(1);
        chk("R4 fall", {7'b0, rst_req}, 8'h00);
        edges(BASE - 1);
        chk("R4 before second", {7'b0, rst_req}, 8'h00);
        edges(1);
        chk("R4 second rise", {7'b0, rst_req}, 8'h01);
    endtask

    task automatic t_kick;
        do_reset();
        wr(cfgb(1, 0, 1));
        edges(5);
        wr(cfgb(1, 1, 1));
        edges(2 * BASE);
        chk("R5 no early request", {7'b0, rst_req}, 8'h00);
        edges(1);
        chk("R5 request after kick", {7'b0, rst_req}, 8'h01);
    endtask

    task automatic t_absorb;
        do_reset();
        wr(cfgb(0, 0, 1));
        edges(1);
        wr(cfgb(0, 1, 1));
        edges(2);
        wr(cfgb(0, 1, 1));
        edges(2);
        chk("R6 absorbed kick, before", {7'b0, rst_req}, 8'h00);
        edges(1);
        chk("R6 absorbed kick, request", {7'b0, rst_req}, 8'h01);
        do_reset();
        wr(cfgb(0, 0, 1));
        edges(1);
        wr(cfgb(0, 1, 1));
        icyc();
        wr(cfgb(0, 1, 1));
        edges(BASE);
        chk("R6 released kick, before", {7'b0, rst_req}, 8'h00);
        edges(1);
        chk("R6 released kick, request", {7'b0, rst_req}, 8'h01);
    endtask

    task automatic t_disable;
        do_reset();
        wr(cfgb(0, 0, 1));
        edges(2);
        wr(cfgb(0, 0, 0));
        edges(30);
        chk("R7 stopped", {7'b0, rst_req}, 8'h00);
        wr(cfgb(0, 0, 1));
        edges(BASE - 1);
        chk("R7 fresh period, before", {7'b0, rst_req}, 8'h00);
        edges(1);
        chk("R7 fresh period, rise", {7'b0, rst_req}, 8'h01);
        wr(cfgb(0, 0, 0));
        chk("R7 write edge still high", {7'b0, rst_req}, 8'h01);
        edges(1);
        chk("R7 drop after disable", {7'b0, rst_req}, 8'h00);
    endtask

    task automatic t_collision;
        do_reset();
        wr(cfgb(0, 0, 1));
        edges(3);
        wr(cfgb(0, 1, 1));
        edges(1);
        chk("R8 collision no request", {7'b0, rst_req}, 8'h00);
        edges(BASE - 1);
        chk("R8 before next", {7'b0, rst_req}, 8'h00);
        edges(1);
        chk("R8 next request", {7'b0, rst_req}, 8'h01);
    endtask

    task automatic t_disabled_quiet;
        bit seen;
        do_reset();
        wr(cfgb(0, 1, 0));
        icyc();
        wr(cfgb(3, 1, 0));
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            edges(1);
            if (rst_req) seen = 1'b1;
        end
        chk("R9 quiet while disabled", {7'b0, seen}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not end, got hung expected done");
        report();
    end

    initial begin
        t_reset_state();
        t_read_view();
        t_period(0);
        t_period(2);
        t_period(7);
        t_hold();
        t_kick();
        t_absorb();
        t_disable();
        t_collision();
        t_disabled_quiet();
        report();
    end

endmodule